// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous on-chip logic use an external asynchronous static RAM of 131,072 sixteen-bit words, split into a lower and an upper byte lane. A client presents a word address, a read/write flag, write data and a two-bit lane mask on a request/ready handshake. The controller then drives the memory's active-low strobes for the fixed number of clock cycles that the memory's access and pulse-width timings require. Read data comes back on a registered port with a single-cycle valid strobe.

Two parameters give the read wait and the write-enable pulse width as clock counts. They are rounded up from the memory's timings over the clock period. A write uses the write-enable-controlled form. Chip enable, address, lane enables and data settle one cycle before write enable falls and stay one cycle after it rises. A read uses the address-controlled form. Chip enable and output enable are held low for the whole wait, and the data pins are sampled on the last wait cycle. The controller does not drive the shared data pins while the memory's outputs are on. It always leaves at least one idle cycle between a write and the next read.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and just after it is released, `req_ready` is 1, `rsp_valid` is 0, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, both bits of `mem_be_n` are 1, and `mem_dq_oe` is 0.
- R2: During any access (`mem_ce_n` low), `mem_be_n[0]` (lower lane, data bits 7:0) is low exactly when request mask bit 0 was 1. `mem_be_n[1]` (upper lane, bits 15:8) is low exactly when mask bit 1 was 1. At least one lane enable is low.
- R3: A write holds `mem_we_n` low for exactly WR_PULSE cycles. `mem_ce_n` is low and `mem_we_n` is high for one cycle before and one cycle after the pulse. Address, lane enables and `mem_dq_o` stay unchanged through the pulse and the cycle after it. `mem_dq_oe` is 1 and `mem_oe_n` is 1 for the whole write.
- R4: A write changes only the lanes selected by its mask. A later full-mask read returns the old content in the unselected lane and the new data in the selected lane.
- R5: A read holds `mem_ce_n` and `mem_oe_n` low, with the request address on `mem_addr`, for RD_WAIT cycles. `rsp_valid` is high for exactly one cycle, in the cycle after the last wait cycle, which is RD_WAIT+1 cycles after the accepting edge.
- R6: In read data, a lane whose mask bit is 0 returns zero, whatever the data pins carry.
- R7: `req_ready` is low from the accepting edge until the access ends. A write with a nonzero mask returns `req_ready` high WR_PULSE+3 cycles after acceptance.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. Between the last driven cycle of a write and a read's output enable there is at least one cycle with `mem_dq_oe` 0.
- R9: A request with mask 0 never drives `mem_ce_n` low and finishes in one cycle. For a read, `rsp_valid` pulses two cycles after acceptance with all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Lane select, bit 0 = lower byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Lane enables, active low, bit 0 = lower byte |
| mem_dq_o | output | DATA_W | Data toward the pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | DATA_W | Data from the pad |

## Verification
The bench sweeps all four lane masks for writes and all four for reads at several addresses, including the lowest and highest. Each read is checked against a shadow image that the bench merges by arithmetic, so a swapped or ignored lane enable and an unmasked read lane each show up as a mismatch. The memory model returns garbage until output enable has been low for RD_WAIT-1 edges, which separates a correct read wait from a short one. Writes directly followed by reads exercise bus turnaround, and zero-mask requests of both kinds confirm that chip enable never falls.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHOLD,
    ST_RD,
    ST_NOP
  } state_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pin_ctl_t;

  // Strobe levels that belong to each state; registered by the top.
  function automatic pin_ctl_t ctl_of(state_t s);
    pin_ctl_t c;
    c.ce_n  = !(s inside {ST_WSET, ST_WPUL, ST_WHOLD, ST_RD});
    c.oe_n  = (s != ST_RD);
    c.we_n  = (s != ST_WPUL);
    c.dq_oe = (s inside {ST_WSET, ST_WPUL, ST_WHOLD});
    return c;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // A phase of N cycles is loaded with N; its final cycle sees 1.
  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W/8-1:0] mask,
  output logic [DATA_W/8-1:0] lane_en_n,
  input  logic [DATA_W-1:0]   rd_pins,
  output logic [DATA_W-1:0]   rd_kept
);
  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en_n[g]        = ~mask[g];
    assign rd_kept[g*8 +: 8]   = mask[g] ? rd_pins[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int RD_WAIT  = 3,
  parameter int WR_PULSE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_i
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = $clog2(max_of(RD_WAIT, WR_PULSE) + 1);

  state_t st_q, st_d;
  pin_ctl_t ctl_d;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  mask_q, mask_sel, lane_en_n;
  logic              write_q;
  logic [DATA_W-1:0] rd_kept;

  // Named internal events
  logic accept, rd_done, nop_rd_done, tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val;

  assign req_ready   = (st_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign rd_done     = (st_q == ST_RD) && tmr_last;
  assign nop_rd_done = (st_q == ST_NOP) && !write_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) begin
                  if (req_mask == '0)  st_d = ST_NOP;
                  else if (req_write)  st_d = ST_WSET;
                  else                 st_d = ST_RD;
                end
      ST_WSET:  st_d = ST_WPUL;
      ST_WPUL:  if (tmr_last) st_d = ST_WHOLD;
      ST_WHOLD: st_d = ST_IDLE;
      ST_RD:    if (tmr_last) st_d = ST_IDLE;
      ST_NOP:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (st_d != st_q) && (st_d == ST_RD || st_d == ST_WPUL);
  assign tmr_val  = (st_d == ST_RD) ? CNT_W'(RD_WAIT) : CNT_W'(WR_PULSE);
  assign ctl_d    = ctl_of(st_d);
  assign mask_sel = accept ? req_mask : mask_q;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_ctl_lanes #(.DATA_W(DATA_W)) u_lanes_wr (
    .mask      (mask_sel),
    .lane_en_n (lane_en_n),
    .rd_pins   (mem_dq_i),
    .rd_kept   (rd_kept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      write_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q  <= req_addr;
        data_q  <= req_wdata;
        mask_q  <= req_mask;
        write_q <= req_write;
      end
    end
  end

  // Strobes registered from the next state so the pins never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_be_n  <= '1;
    end else begin
      mem_ce_n  <= ctl_d.ce_n;
      mem_oe_n  <= ctl_d.oe_n;
      mem_we_n  <= ctl_d.we_n;
      mem_dq_oe <= ctl_d.dq_oe;
      mem_be_n  <= ctl_d.ce_n ? '1 : lane_en_n;
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done || nop_rd_done;
      if (rd_done)          rsp_rdata <= rd_kept;
      else if (nop_rd_done) rsp_rdata <= '0;
    end
  end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int WR_PULSE = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_ce_n,
  input logic                mem_oe_n,
  input logic                mem_we_n,
  input logic [DATA_W/8-1:0] mem_be_n,
  input logic [DATA_W-1:0]   mem_dq_o,
  input logic                mem_dq_oe
);
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= 0;
    else if (mem_we_n) low_run <= 0;
    else               low_run <= low_run + 1;
  end

  assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_run == WR_PULSE));

  assert_we_ctx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  assert_we_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n));

  assert_we_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr)
                         && $stable(mem_dq_o) && $stable(mem_be_n)));

  assert_wr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_o) && $stable(mem_be_n)));

  assert_lane_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (mem_be_n != '1));

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  assert_no_fight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WR_PULSE (WR_PULSE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
  localparam int AW = 17;
  localparam int DW = 16;
  localparam int RW = 3;
  localparam int WP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be_n;

  always #2 clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RW), .WR_PULSE(WP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  int checks = 0, fails = 0;

  function automatic logic [15:0] keep16(logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // Memory model: 256 words indexed by the low address byte.
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  int rd_age = 0;

  always @(posedge clk)
    if (!mem_ce_n && !mem_oe_n) rd_age <= rd_age + 1; else rd_age <= 0;

  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= RW - 1) begin
      mem_dq_i[7:0]  = mem_be_n[0] ? 8'hA5 : mem[mem_addr[7:0]][7:0];
      mem_dq_i[15:8] = mem_be_n[1] ? 8'h5A : mem[mem_addr[7:0]][15:8];
    end else begin
      mem_dq_i = 16'hDEAD;
    end
  end

  always @(posedge mem_we_n)
    if (mem_ce_n === 1'b0) begin
      if (!mem_be_n[0]) mem[mem_addr[7:0]][7:0]  = mem_dq_oe ? mem_dq_o[7:0]  : 8'hEE;
      if (!mem_be_n[1]) mem[mem_addr[7:0]][15:8] = mem_dq_oe ? mem_dq_o[15:8] : 8'hEE;
    end

  // Pin monitor, sampled mid-cycle.
  logic [AW-1:0] cur_addr = '0;
  logic [1:0]    cur_mask = '0;
  bit prev_oe = 0, ce_seen = 0;
  int we_run = 0, last_pulse = 0, turn_bad = 0, addr_bad = 0, lane_bad = 0;

  always @(negedge clk) if (rst_n) begin
    if (!mem_oe_n && !mem_ce_n && prev_oe) turn_bad++;
    if (!mem_oe_n && mem_dq_oe) turn_bad++;
    prev_oe = mem_dq_oe;
    if (!mem_we_n) we_run++;
    else if (we_run != 0) begin last_pulse = we_run; we_run = 0; end
    if (!mem_ce_n) begin
      ce_seen = 1;
      if (mem_addr != cur_addr) addr_bad++;
      if (mem_be_n != ~cur_mask) lane_bad++;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(bit wr, logic [AW-1:0] a, logic [15:0] d, logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr = a; cur_mask = m; ce_seen = 0; last_pulse = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R7 busy after accept", req_ready, 0);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic [1:0] m);
    int cyc = 1;
    issue(1, a, d, m);
    while (!req_ready && cyc < 50) begin @(negedge clk); cyc++; end
    if (m != 0) begin
      check(cyc == WP + 3, "R7 write length", cyc, WP + 3);
      check(last_pulse == WP, "R3 pulse width", last_pulse, WP);
    end else begin
      check(cyc == 2, "R9 no-op write length", cyc, 2);
      check(!ce_seen, "R9 no chip enable", ce_seen, 0);
    end
    shadow[a[7:0]] = (shadow[a[7:0]] & ~keep16(m)) | (d & keep16(m));
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [1:0] m);
    int cyc = 1;
    logic [15:0] exp;
    issue(0, a, 16'h0, m);
    while (!rsp_valid && cyc < 50) begin @(negedge clk); cyc++; end
    exp = shadow[a[7:0]] & keep16(m);
    if (m != 0) begin
      check(cyc == RW + 1, "R5 read latency", cyc, RW + 1);
      check(rsp_rdata == exp, (m == 2'b11) ? "R4 readback" : "R6 masked read",
            rsp_rdata, exp);
    end else begin
      check(cyc == 2, "R9 no-op read latency", cyc, 2);
      check(rsp_rdata == 16'h0 && !ce_seen, "R9 no-op read data", rsp_rdata, 0);
    end
    @(negedge clk);
    check(rsp_valid == 0, "R5 single strobe", rsp_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [4];
    addrs[0] = 17'h00000; addrs[1] = 17'h00003;
    addrs[2] = 17'h12345; addrs[3] = 17'h1FFFF;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end

    repeat (3) @(negedge clk);
    check(req_ready == 1 && rsp_valid == 0, "R1 handshake reset", {req_ready, rsp_valid}, 2'b10);
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe} == 6'b111110,
          "R1 pins reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 6'b111110);
    rst_n = 1;
    @(negedge clk);
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe} == 6'b111110,
          "R1 pins after release", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 6'b111110);

    for (int i = 0; i < 4; i++) begin
      do_write(addrs[i], 16'h1111 * 16'(i + 1), 2'b11);
      do_read(addrs[i], 2'b11);
    end
    for (int i = 0; i < 4; i++)
      for (int wm = 0; wm < 4; wm++) begin
        do_write(addrs[i], 16'(addrs[i] * 17'h0135) ^ (16'h0F0F * 16'(wm + 1)), 2'(wm));
        for (int rm = 0; rm < 4; rm++) do_read(addrs[i], 2'(rm));
      end
    for (int i = 0; i < 4; i++) do_read(addrs[i], 2'b11);

    check(turn_bad == 0, "R8 bus turnaround", turn_bad, 0);
    check(addr_bad == 0, "R5 address held", addr_bad, 0);
    check(lane_bad == 0, "R2 lane enables", lane_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule